// File: doc/BRIEF.md
# Event Counter Bank with Negative-Value Alert

This block holds six 32-bit event counters. Software reaches them and two configuration registers through a simple register port: one write and one read each cycle. Each cycle the block takes a cycle tick and the number of instructions completed in that cycle. Each counter adds the event it has been given. Counters 1 to 4 select their event through an 8-bit code in a shared event-select register. Counter 5 counts completed instructions and counter 6 counts cycles, whatever the event codes hold.

A counter is "negative" when its top bit is set. The control register has two alert enables. One gates counter 1 alone. The other gates counters 2 to 6 together. A single registered alert output is the OR of every counter's negative condition, each gated by its own enable. The alert stays high for as long as such a condition holds, so software drops it by rewriting the counter or by clearing the enable.

Top module: `pmc_bank`

## Requirements
- R1: After synchronous reset, all counters, the control register, the event-select register, `rd_data` and `alert` are zero.
- R2: Register addresses are: 0 control (bit 0 `en_first`, bit 1 `en_rest`; other bits are not stored and read as 0), 1 to 6 counters 1 to 6, 7 event select (counter k uses bits [8k-1:8k-8]), anything else reads 0. `rd_data` shows, one cycle after `rd_addr` is presented, the register contents before that clock edge.
- R3: A counter among 1 to 4 adds `inst_cnt` when its event code is 0x02, adds `cyc_tick` when its code is 0x1E, and holds its value for any other code.
- R4: Counter 5 adds `inst_cnt` and counter 6 adds `cyc_tick` every cycle, regardless of the event-select register.
- R5: `inst_cnt` ranges over 0 to 2 and is added in full in a single cycle. Counters wrap modulo 2^32.
- R6: A write to a counter in the same cycle as an increment stores the written value, and the increment is dropped.
- R7: Counter 1 can raise the alert only while `en_first` is set. `en_rest` has no effect on it.
- R8: Counters 2 to 6 can raise the alert only while `en_rest` is set.
- R9: `alert` is registered: it is high in the cycle after any enabled counter holds a value with bit 31 set. This includes a value written already negative, whatever that counter's event code. It stays high until no enabled counter is negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One processor cycle elapsed |
| inst_cnt | input | 2 | Instructions completed this cycle (0 to 2) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| alert | output | 1 | Registered negative-counter alert |

## Verification
Two things can land on the same counter in the same cycle: a software write and an event increment. The bench provokes this in two ways. Directed steps write counter 6 while `cyc_tick` is high. Random traffic writes to all registers while ticks and instruction counts keep arriving. A reference model gives the write priority, and every result is judged against it through read-backs. A second collision also occurs: a write that pushes a counter past the sign boundary, or clears its enable, while the alert register updates. The model predicts the alert one cycle behind the state change, and the bench compares it on every step.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  // Source of a counter's increment
  typedef enum logic [1:0] {
    SRC_PROG = 2'd0,   // event chosen by the event-select field
    SRC_INST = 2'd1,   // always completed instructions
    SRC_CYC  = 2'd2    // always cycles
  } src_e;

  // Event codes understood by the programmable counters
  localparam logic [7:0] EVT_INST = 8'h02;
  localparam logic [7:0] EVT_CYC  = 8'h1E;

  // Control register bit positions
  localparam int unsigned CTRL_EN_FIRST = 0;
  localparam int unsigned CTRL_EN_REST  = 1;

endpackage

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int   CNT_W  = 32,
  parameter int   INST_W = 2,
  parameter int   EVT_W  = 8,
  parameter src_e SRC    = SRC_PROG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_sel,
  input  logic              cyc_tick,
  input  logic [INST_W-1:0] inst_cnt,
  input  logic              wr_hit,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  value,
  output logic              negative
);

  logic [CNT_W-1:0] step;

  generate
    if (SRC == SRC_INST) begin : g_inst
      logic unused_evt;
      assign unused_evt = ^evt_sel;
      assign step = CNT_W'(inst_cnt);
    end else if (SRC == SRC_CYC) begin : g_cyc
      logic unused_evt;
      assign unused_evt = ^evt_sel;
      assign step = CNT_W'(cyc_tick);
    end else begin : g_prog
      always_comb begin
        step = '0;
        if (evt_sel == EVT_W'(EVT_INST)) begin
          step = CNT_W'(inst_cnt);
        end else if (evt_sel == EVT_W'(EVT_CYC)) begin
          step = CNT_W'(cyc_tick);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (wr_hit) begin
      value <= wr_data;
    end else begin
      value <= value + step;
    end
  end

  assign negative = value[CNT_W-1];

endmodule

// File: rtl/pmc_regfile.sv
module pmc_regfile
  import pmc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_CNT  = 6,
  parameter int ADDR_W   = 3,
  parameter int EVT_W    = 8,
  parameter int NUM_PROG = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [CNT_W-1:0]                 wr_data,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]    cnt_vals,
  output logic                             en_first,
  output logic                             en_rest,
  output logic [NUM_PROG-1:0][EVT_W-1:0]   evsel,
  output logic [CNT_W-1:0]                 rd_data
);

  localparam int EVS_W     = NUM_PROG * EVT_W;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_EVT  = NUM_CNT + 1;

  logic [CNT_W-1:0] rd_next;
  logic [CNT_W-1:0] ctrl_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_first <= 1'b0;
      en_rest  <= 1'b0;
      evsel    <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
        en_first <= wr_data[CTRL_EN_FIRST];
        en_rest  <= wr_data[CTRL_EN_REST];
      end
      if (wr_addr == ADDR_W'(ADDR_EVT)) begin
        evsel <= wr_data[EVS_W-1:0];
      end
    end
  end

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CTRL_EN_FIRST] = en_first;
    ctrl_view[CTRL_EN_REST]  = en_rest;
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
      rd_next = ctrl_view;
    end else if (rd_addr == ADDR_W'(ADDR_EVT)) begin
      rd_next = CNT_W'(evsel);
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (rd_addr == ADDR_W'(i + 1)) begin
          rd_next = cnt_vals[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_next;
    end
  end

endmodule

// File: rtl/pmc_alert.sv
module pmc_alert #(
  parameter int NUM_CNT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] neg,
  input  logic               en_first,
  input  logic               en_rest,
  output logic               alert
);

  logic first_hit;
  logic rest_hit;

  assign first_hit = en_first & neg[0];
  assign rest_hit  = en_rest  & (|neg[NUM_CNT-1:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      alert <= 1'b0;
    end else begin
      alert <= first_hit | rest_hit;
    end
  end

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = 6,
  parameter int EVT_W   = 8,
  parameter int INST_W  = 2,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_tick,
  input  logic [INST_W-1:0] inst_cnt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              alert
);

  localparam int NUM_PROG = NUM_CNT - 2;

  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_vals;
  logic [NUM_CNT-1:0]             cnt_neg;
  logic [NUM_CNT-1:0]             wr_hit;
  logic [NUM_PROG-1:0][EVT_W-1:0] evsel;
  logic                           en_first;
  logic                           en_rest;

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i + 1));
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
      if (gi < NUM_PROG) begin : g_prog
        pmc_counter #(
          .CNT_W(CNT_W), .INST_W(INST_W), .EVT_W(EVT_W), .SRC(SRC_PROG)
        ) u_cnt (
          .clk(clk), .rst(rst), .evt_sel(evsel[gi]),
          .cyc_tick(cyc_tick), .inst_cnt(inst_cnt),
          .wr_hit(wr_hit[gi]), .wr_data(wr_data),
          .value(cnt_vals[gi]), .negative(cnt_neg[gi])
        );
      end else begin : g_fixed
        pmc_counter #(
          .CNT_W(CNT_W), .INST_W(INST_W), .EVT_W(EVT_W),
          .SRC((gi == NUM_CNT - 2) ? SRC_INST : SRC_CYC)
        ) u_cnt (
          .clk(clk), .rst(rst), .evt_sel('0),
          .cyc_tick(cyc_tick), .inst_cnt(inst_cnt),
          .wr_hit(wr_hit[gi]), .wr_data(wr_data),
          .value(cnt_vals[gi]), .negative(cnt_neg[gi])
        );
      end
    end
  endgenerate

  pmc_regfile #(
    .CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W),
    .EVT_W(EVT_W), .NUM_PROG(NUM_PROG)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cnt_vals(cnt_vals),
    .en_first(en_first), .en_rest(en_rest), .evsel(evsel),
    .rd_data(rd_data)
  );

  pmc_alert #(
    .NUM_CNT(NUM_CNT)
  ) u_alert (
    .clk(clk), .rst(rst), .neg(cnt_neg),
    .en_first(en_first), .en_rest(en_rest), .alert(alert)
  );

endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
  import pmc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = 6,
  parameter int EVT_W   = 8,
  parameter int INST_W  = 2,
  parameter int ADDR_W  = 3
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               cyc_tick,
  input logic [INST_W-1:0]                  inst_cnt,
  input logic                               wr_en,
  input logic [ADDR_W-1:0]                  wr_addr,
  input logic [CNT_W-1:0]                   wr_data,
  input logic                               alert,
  input logic [NUM_CNT-1:0][CNT_W-1:0]      cnt_vals,
  input logic [NUM_CNT-1:0]                 neg,
  input logic                               en_first,
  input logic                               en_rest,
  input logic [NUM_CNT-3:0][EVT_W-1:0]      evsel
);

  localparam int NUM_PROG = NUM_CNT - 2;

  AST_INST_RANGE: assert property (@(posedge clk) disable iff (rst)
    inst_cnt <= INST_W'(2)); // R5

  AST_INST_COUNT: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADDR_W'(NUM_CNT - 1))
    |=> cnt_vals[NUM_CNT-2] == $past(cnt_vals[NUM_CNT-2]) + CNT_W'($past(inst_cnt))); // R5

  AST_CYC_COUNT: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADDR_W'(NUM_CNT))
    |=> cnt_vals[NUM_CNT-1] == $past(cnt_vals[NUM_CNT-1]) + CNT_W'($past(cyc_tick))); // R4

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_wr
      AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(gi + 1))
        |=> cnt_vals[gi] == $past(wr_data)); // R6
    end
    for (gi = 0; gi < NUM_PROG; gi++) begin : g_idle
      AST_PROG_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_addr == ADDR_W'(gi + 1)) &&
         evsel[gi] != EVT_W'(EVT_INST) && evsel[gi] != EVT_W'(EVT_CYC))
        |=> $stable(cnt_vals[gi])); // R3
    end
  endgenerate

  AST_ALERT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (en_first && neg[0]) |=> alert); // R7

  AST_ALERT_REST: assert property (@(posedge clk) disable iff (rst)
    (en_rest && (|neg[NUM_CNT-1:1])) |=> alert); // R8

  AST_ALERT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!en_first && !en_rest) |=> !alert); // R9

endmodule

bind pmc_bank pmc_bank_chk #(
  .CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .EVT_W(EVT_W),
  .INST_W(INST_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .inst_cnt(inst_cnt),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .alert(alert),
  .cnt_vals(cnt_vals), .neg(cnt_neg), .en_first(en_first),
  .en_rest(en_rest), .evsel(evsel)
);

// File: tb/pmc_bank_bench.sv
module pmc_bank_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        cyc_tick;
  logic [1:0]  inst_cnt;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        alert;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // Reference model state
  logic [31:0] m_cnt [6];
  logic        m_en1;
  logic        m_enr;
  logic [31:0] m_evt;

  always #4 clk = ~clk;  // 125 MHz

  pmc_bank u_pmc_bank (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .inst_cnt(inst_cnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .alert(alert)
  );

  function automatic logic [31:0] model_inc(int idx, logic tick, logic [1:0] inst);
    logic [7:0] code;
    if (idx == 4) return {30'd0, inst};
    if (idx == 5) return {31'd0, tick};
    code = m_evt[8*idx +: 8];
    if (code == 8'h02) return {30'd0, inst};
    if (code == 8'h1E) return {31'd0, tick};
    return 32'd0;
  endfunction

  function automatic logic [31:0] model_read(logic [2:0] a);
    if (a == 3'd0) return {30'd0, m_enr, m_en1};
    if (a == 3'd7) return m_evt;
    return m_cnt[a - 3'd1];
  endfunction

  function automatic logic model_alert();
    logic rest = 1'b0;
    for (int i = 1; i < 6; i++) rest = rest | m_cnt[i][31];
    return (m_en1 & m_cnt[0][31]) | (m_enr & rest);
  endfunction

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // One clock step: drive at negedge, compare at the following negedge
  task automatic step(logic we, logic [2:0] wa, logic [31:0] wd, logic [2:0] ra,
                      logic tick, logic [1:0] inst, string tag);
    logic [31:0] exp_rd;
    logic        exp_al;
    logic [31:0] nxt [6];
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    cyc_tick = tick; inst_cnt = inst;
    exp_rd = model_read(ra);
    exp_al = model_alert();
    for (int i = 0; i < 6; i++) begin
      if (we && wa == 3'(i + 1)) nxt[i] = wd;
      else nxt[i] = m_cnt[i] + model_inc(i, tick, inst);
    end
    @(posedge clk);
    for (int i = 0; i < 6; i++) m_cnt[i] = nxt[i];
    if (we && wa == 3'd0) begin m_en1 = wd[0]; m_enr = wd[1]; end
    if (we && wa == 3'd7) m_evt = wd;
    @(negedge clk);
    check32(tag, "rd_data", rd_data, exp_rd);
    check32(tag, "alert", {31'd0, alert}, {31'd0, exp_al});
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    step(1'b1, a, d, 3'd0, 1'b0, 2'd0, tag);
  endtask

  task automatic rd(logic [2:0] a, string tag);
    step(1'b0, 3'd0, 32'd0, a, 1'b0, 2'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) m_cnt[i] = 32'd0;
    m_en1 = 1'b0; m_enr = 1'b0; m_evt = 32'd0;
    rst = 1'b1; cyc_tick = 1'b0; inst_cnt = 2'd0;
    wr_en = 1'b0; wr_addr = 3'd0; wr_data = 32'd0; rd_addr = 3'd0;
    void'($urandom(32'd20211));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state on the ports, then every register reads zero
    check32("R1", "rd_data", rd_data, 32'd0);
    check32("R1", "alert", {31'd0, alert}, 32'd0);
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");

    // R2: event-select and control read-back, unstored control bits
    wr(3'd7, 32'h1E55021E, "R2");
    rd(3'd7, "R2");
    wr(3'd0, 32'hFFFF_FFFC, "R2");
    rd(3'd0, "R2");

    // R3: counter 1 on cycles, counter 2 on instructions, counter 3 invalid
    step(1'b0, 3'd0, 32'd0, 3'd1, 1'b1, 2'd2, "R3");
    step(1'b0, 3'd0, 32'd0, 3'd2, 1'b1, 2'd1, "R3");
    step(1'b0, 3'd0, 32'd0, 3'd3, 1'b1, 2'd2, "R3");
    rd(3'd1, "R3"); rd(3'd2, "R3"); rd(3'd3, "R3");

    // R7 / R9: counter 1 crosses into negative by a cycle tick
    wr(3'd1, 32'h7FFF_FFFF, "R7");
    wr(3'd0, 32'h0000_0001, "R7");
    step(1'b0, 3'd0, 32'd0, 3'd1, 1'b1, 2'd0, "R9");
    rd(3'd1, "R9");
    rd(3'd1, "R9");
    // R7: shared enable alone must not let counter 1 alert
    wr(3'd0, 32'h0000_0002, "R7");
    rd(3'd0, "R7"); rd(3'd0, "R7");

    // R8 / R9: counter 3 (invalid event) written negative alerts immediately
    wr(3'd3, 32'h9000_0000, "R8");
    step(1'b0, 3'd0, 32'd0, 3'd3, 1'b1, 2'd2, "R8");
    rd(3'd3, "R3");
    // R9: clearing counters 1 and 3 lowers the alert
    wr(3'd3, 32'h0000_0000, "R9");
    wr(3'd1, 32'h0000_0000, "R9");
    rd(3'd0, "R9"); rd(3'd0, "R9");

    // R5: counter 5 wraps with a full add of two
    wr(3'd5, 32'hFFFF_FFFF, "R5");
    step(1'b0, 3'd0, 32'd0, 3'd5, 1'b0, 2'd2, "R5");
    rd(3'd5, "R5");

    // R4: fixed counters ignore event-select
    wr(3'd7, 32'h0000_0000, "R4");
    step(1'b0, 3'd0, 32'd0, 3'd6, 1'b1, 2'd1, "R4");
    rd(3'd6, "R4"); rd(3'd5, "R4");

    // R6: write to counter 6 in a ticking cycle wins
    step(1'b1, 3'd6, 32'h7FFF_FFFF, 3'd6, 1'b1, 2'd2, "R6");
    rd(3'd6, "R6");
    step(1'b0, 3'd0, 32'd0, 3'd6, 1'b1, 2'd0, "R8");
    rd(3'd6, "R8");
    // R9: clearing the enables drops the alert
    wr(3'd0, 32'h0000_0000, "R9");
    rd(3'd0, "R9"); rd(3'd0, "R9");

    // Random traffic mixing writes, ticks and instruction counts
    for (int n = 0; n < 4000; n++) begin
      logic        we;
      logic [2:0]  wa;
      logic [31:0] wd;
      we = ($urandom % 6) == 0;
      wa = 3'($urandom % 8);
      if ($urandom % 2) wd = 32'h7FFF_FFF0 + ($urandom % 32);
      else if ($urandom % 3 == 0) wd = 32'hFFFF_FFF8 + ($urandom % 8);
      else wd = $urandom;
      if (wa == 3'd7) begin
        wd = {($urandom % 2) ? 8'h1E : 8'h02, ($urandom % 2) ? 8'h02 : 8'h1E,
              ($urandom % 3 == 0) ? 8'h40 : 8'h1E, ($urandom % 2) ? 8'h02 : 8'h1E};
      end
      step(we, wa, wd, 3'($urandom % 8), 1'($urandom % 2), 2'($urandom % 3), "R6");
    end

    wr_en = 1'b0;
    done  = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule